// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block steps a multichannel analog-to-digital converter through a sequence of four or eight conversions. A control write loads three settings: a sequence-length select, a multichannel enable and a 4-bit channel code. The write also starts a fresh sequence at slot 0. For each slot the block drives a 4-bit channel code to the analog multiplexer and pulses a start strobe. It then waits for the converter's done pulse and stores the returned word in an 8-entry result file, at the slot's index.

In single-channel mode every slot converts the channel given by the full code. In multichannel mode the low bits of the code are ignored and the slot number supplies them, so that a group of consecutive channels is converted in ascending order. Channel codes 0 to 7 are external inputs and codes 8 to 11 are reserved. Codes 12 to 15 are internal sources: high reference, low reference, mid reference and a test source. When the last slot has been written, a completion flag rises and stays high until the next control write.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With length select 0 a sequence has exactly 4 conversions (slots 0 to 3). With length select 1 it has exactly 8 (slots 0 to 7).
- R2: With multichannel enable 0, every slot drives the stored 4-bit channel code unchanged on conv_mux.
- R3: With multichannel enable 1 and length select 0, slot k drives {chan[3:2], k[1:0]}. chan[1:0] has no effect.
- R4: With multichannel enable 1 and length select 1, slot k drives {chan[3], k[2:0]}. chan[2:0] has no effect.
- R5: Multichannel group codes are converted as plain codes. Code 4'b10xx gives the reserved codes 8 to 11 in ascending order. Code 4'b11xx gives 12, 13, 14 and 15 (high, low, mid reference, test) in that order.
- R6: The data word returned with conv_done while slot k is converting is written to result entry k, and rd_data shows entry rd_idx combinationally.
- R7: conv_start is a single-cycle pulse. No new start is issued until conv_done has been seen. conv_mux holds steady while the block waits. A conv_done that arrives while no conversion is awaited writes nothing.
- R8: A cfg_we pulse aborts any running sequence and issues a start for slot 0 of the new setting in the next cycle. A conv_done in the same cycle as cfg_we writes nothing.
- R9: seq_complete goes high in the cycle after the last slot's result is written. It stays high while the block is idle, and it is low in the cycle after cfg_we.
- R10: After reset no start is issued, seq_complete is low and every result entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe; loads the settings and restarts the sequence |
| cfg_len8 | input | 1 | Length select: 0 = 4 conversions, 1 = 8 conversions |
| cfg_multi | input | 1 | Multichannel enable |
| cfg_chan | input | 4 | Channel code |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_mux | output | 4 | Channel code driven to the analog multiplexer |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DATA_W | Conversion result, valid with conv_done |
| res_we | output | 1 | Result-file write strobe |
| res_idx | output | 3 | Result-file write index (current slot) |
| seq_complete | output | 1 | Sequence complete flag |
| rd_idx | input | 3 | Result read index |
| rd_data | output | DATA_W | Result entry selected by rd_idx |

## Verification
The assertions check on every cycle how the slots map to channels in all three modes and how result indices advance in order. They also check that a start is always followed by a quiet cycle, that the multiplexer stays steady during a wait, and that stray done pulses are refused. Restart on a control write and the setting and clearing of the completion flag are also checked every cycle. Only the bench's scenarios can show the rest. These are the true count of conversions per sequence, that the stored words match what the converter returned, the reserved and reference code groups, and that a result entry keeps its value after an aborted or refused done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CHAN_W = 4;
  localparam int SLOT_W = 3;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic              len8;
    logic              multi;
    logic [CHAN_W-1:0] chan;
  } seq_cfg_t;

  // Highest slot index of a sequence.
  function automatic logic [SLOT_W-1:0] last_slot(input logic len8);
    return len8 ? SLOT_W'(SLOTS - 1) : SLOT_W'(SLOTS / 2 - 1);
  endfunction

  // Channel code converted in a given slot.
  function automatic logic [CHAN_W-1:0] slot_channel(input seq_cfg_t c,
                                                     input logic [SLOT_W-1:0] slot);
    logic [CHAN_W-1:0] code;
    if (!c.multi)      code = c.chan;
    else if (c.len8)   code = {c.chan[3], slot};
    else               code = {c.chan[3:2], slot[1:0]};
    return code;
  endfunction

endpackage

// File: rtl/adc_seq_cfg_reg.sv
module adc_seq_cfg_reg
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  seq_cfg_t wr_cfg,
  output seq_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_cfg;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              len8,
  input  logic              done,
  output logic              start,
  output logic              waiting,
  output logic              wr_en,
  output logic [SLOT_W-1:0] slot,
  output logic              complete
);

  seq_state_t state_q;
  logic [SLOT_W-1:0] slot_q;
  logic complete_q;
  logic at_last;

  assign at_last = (slot_q == last_slot(len8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      complete_q <= 1'b0;
    end else if (restart) begin
      state_q    <= ST_START;
      slot_q     <= '0;
      complete_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done) begin
            if (at_last) begin
              state_q    <= ST_IDLE;
              complete_q <= 1'b1;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_START;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start    = (state_q == ST_START);
  assign waiting  = (state_q == ST_WAIT);
  assign wr_en    = waiting && done && !restart;
  assign slot     = slot_q;
  assign complete = complete_q;

endmodule

// File: rtl/adc_seq_result_file.sv
module adc_seq_result_file
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] entry_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              entry_q[i] <= '0;
      else if (wr_en && wr_idx == SLOT_W'(i))  entry_q[i] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_len8,
  input  logic              cfg_multi,
  input  logic [3:0]        cfg_chan,
  output logic              conv_start,
  output logic [3:0]        conv_mux,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_we,
  output logic [2:0]        res_idx,
  output logic              seq_complete,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  seq_cfg_t wr_cfg, cfg_q;
  logic [SLOT_W-1:0] slot;
  logic in_conv;
  logic cfg_len8_q, cfg_multi_q;
  logic [CHAN_W-1:0] cfg_chan_q;

  assign wr_cfg = '{len8: cfg_len8, multi: cfg_multi, chan: cfg_chan};

  adc_seq_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  adc_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_we),
    .len8     (cfg_q.len8),
    .done     (conv_done),
    .start    (conv_start),
    .waiting  (in_conv),
    .wr_en    (res_we),
    .slot     (slot),
    .complete (seq_complete)
  );

  adc_seq_result_file #(.DATA_W(DATA_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (res_we),
    .wr_idx  (slot),
    .wr_data (conv_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  assign conv_mux    = slot_channel(cfg_q, slot);
  assign res_idx     = slot;
  assign cfg_len8_q  = cfg_q.len8;
  assign cfg_multi_q = cfg_q.multi;
  assign cfg_chan_q  = cfg_q.chan;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_len8_q,
  input logic       cfg_multi_q,
  input logic [3:0] cfg_chan_q,
  input logic       conv_start,
  input logic [3:0] conv_mux,
  input logic       conv_done,
  input logic       in_conv,
  input logic       res_we,
  input logic [2:0] res_idx,
  input logic       seq_complete
);

  logic [2:0] exp_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_slot <= '0;
    else if (cfg_we) exp_slot <= '0;
    else if (res_we) exp_slot <= exp_slot + 3'd1;
  end

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_idx == exp_slot); // R1
  AST_SINGLE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cfg_multi_q) |-> conv_mux == cfg_chan_q); // R2
  AST_GROUP4_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && cfg_multi_q && !cfg_len8_q) |->
      (conv_mux[3:2] == cfg_chan_q[3:2] && conv_mux[1:0] == exp_slot[1:0])); // R3
  AST_GROUP8_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && cfg_multi_q && cfg_len8_q) |->
      (conv_mux[3] == cfg_chan_q[3] && conv_mux[2:0] == exp_slot)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R7
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && !conv_done && !cfg_we) |=> $stable(conv_mux)); // R7
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !in_conv) |-> !res_we); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (conv_start && res_idx == 3'd0)); // R8
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !res_we); // R8
  AST_COMPLETE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && !cfg_we && res_idx == (cfg_len8_q ? 3'd7 : 3'd3)) |=> seq_complete); // R9
  AST_COMPLETE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !seq_complete); // R9

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_len8_q   (cfg_len8_q),
  .cfg_multi_q  (cfg_multi_q),
  .cfg_chan_q   (cfg_chan_q),
  .conv_start   (conv_start),
  .conv_mux     (conv_mux),
  .conv_done    (conv_done),
  .in_conv      (in_conv),
  .res_we       (res_we),
  .res_idx      (res_idx),
  .seq_complete (seq_complete)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_len8 = 1'b0, cfg_multi = 1'b0;
  logic [3:0] cfg_chan = '0;
  logic conv_start;
  logic [3:0] conv_mux;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic res_we;
  logic [2:0] res_idx;
  logic seq_complete;
  logic [2:0] rd_idx = '0;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit model_en = 1'b0;
  int n_st = 0;
  logic [3:0] mux_log [16];
  logic [DW-1:0] data_log [16];

  always #10 clk = ~clk;

  adc_seq_ctrl #(.DATA_W(DW)) i_adc_seq_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_len8, .cfg_multi, .cfg_chan,
    .conv_start, .conv_mux, .conv_done, .conv_data,
    .res_we, .res_idx, .seq_complete, .rd_idx, .rd_data
  );

  function automatic logic [3:0] want_mux(input bit l8, input bit mc,
                                          input logic [3:0] ch, input int k);
    if (!mc) return ch;
    if (l8)  return (ch & 4'h8) + 4'(k);
    return (ch & 4'hC) + 4'(k % 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_res(input int k, output logic [DW-1:0] v);
    rd_idx = 3'(k);
    #1 v = rd_data;
  endtask

  task automatic cfg_write(input bit l8, input bit mc, input logic [3:0] ch);
    @(negedge clk);
    cfg_len8 = l8; cfg_multi = mc; cfg_chan = ch; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Converter model: responds to each start after 1..4 cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (model_en) conv_done = 1'b0;
      if (model_en && conv_start) begin
        int lat;
        logic [DW-1:0] d;
        lat = $urandom_range(1, 4);
        d = DW'($urandom);
        mux_log[n_st % 16]  = conv_mux;
        data_log[n_st % 16] = d;
        n_st++;
        repeat (lat) @(negedge clk);
        conv_done = 1'b1;
        conv_data = d;
      end
    end
  end

  task automatic run_seq(input bit l8, input bit mc, input logic [3:0] ch, input string req);
    int nslot;
    int t;
    logic [DW-1:0] v;
    nslot = l8 ? 8 : 4;
    n_st = 0;
    cfg_write(l8, mc, ch);
    chk(seq_complete == 1'b0, "R9", int'(seq_complete), 0);
    t = 0;
    while (!seq_complete && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(seq_complete == 1'b1, "R9", int'(seq_complete), 1);
    chk(n_st == nslot, "R1", n_st, nslot);
    for (int k = 0; k < nslot && k < n_st; k++) begin
      logic [3:0] e;
      e = want_mux(l8, mc, ch, k);
      chk(mux_log[k] == e, req, int'(mux_log[k]), int'(e));
      read_res(k, v);
      chk(v == data_log[k], "R6", int'(v), int'(data_log[k]));
    end
  endtask

  task automatic man_slot(input logic [3:0] exp_mux, input logic [DW-1:0] d, input string req);
    chk(conv_start == 1'b1, "R7", int'(conv_start), 1);
    chk(conv_mux == exp_mux, req, int'(conv_mux), int'(exp_mux));
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(conv_start == 1'b0, "R10", int'(conv_start), 0);
    chk(seq_complete == 1'b0, "R10", int'(seq_complete), 0);
    for (int k = 0; k < 8; k++) begin
      read_res(k, v);
      chk(v == '0, "R10", int'(v), 0);
    end

    // Directed: stray done, abort, reference group (manual converter)
    cfg_write(1'b0, 1'b0, 4'd5);
    chk(conv_start == 1'b1, "R8", int'(conv_start), 1);
    chk(conv_mux == 4'd5, "R2", int'(conv_mux), 5);
    conv_done = 1'b1; conv_data = 10'h0AA;   // during start: must be refused
    @(negedge clk);
    conv_done = 1'b0;
    read_res(0, v);
    chk(v == '0, "R7", int'(v), 0);
    chk(conv_start == 1'b0, "R7", int'(conv_start), 0);
    @(negedge clk);
    conv_done = 1'b1; conv_data = 10'h155;
    @(negedge clk);
    conv_done = 1'b0;
    read_res(0, v);
    chk(v == 10'h155, "R6", int'(v), 'h155);
    chk(conv_mux == 4'd5, "R2", int'(conv_mux), 5);
    @(negedge clk);                          // waiting on slot 1
    cfg_len8 = 1'b0; cfg_multi = 1'b1; cfg_chan = 4'b1110;
    cfg_we = 1'b1; conv_done = 1'b1; conv_data = 10'h3FF;
    @(negedge clk);
    cfg_we = 1'b0; conv_done = 1'b0;
    chk(res_idx == 3'd0, "R8", int'(res_idx), 0);
    read_res(1, v);
    chk(v == '0, "R8", int'(v), 0);
    chk(seq_complete == 1'b0, "R9", int'(seq_complete), 0);
    for (int k = 0; k < 4; k++) man_slot(4'(12 + k), DW'(16 * k + 3), "R5");
    chk(seq_complete == 1'b1, "R9", int'(seq_complete), 1);
    read_res(3, v);
    chk(v == DW'(51), "R6", int'(v), 51);
    repeat (5) @(negedge clk);
    chk(seq_complete == 1'b1, "R9", int'(seq_complete), 1);
    chk(conv_start == 1'b0, "R1", int'(conv_start), 0);

    // Directed mode corners with the converter model
    model_en = 1'b1;
    run_seq(1'b0, 1'b1, 4'b1001, "R5");
    run_seq(1'b1, 1'b1, 4'b1011, "R5");
    run_seq(1'b1, 1'b1, 4'b0111, "R4");
    run_seq(1'b0, 1'b1, 4'b0110, "R3");
    run_seq(1'b1, 1'b0, 4'd14, "R2");
    run_seq(1'b0, 1'b0, 4'd3, "R2");

    // Constrained random sequences
    for (int i = 0; i < 24; i++) begin
      bit l8, mc;
      logic [3:0] ch;
      l8 = 1'($urandom);
      mc = 1'($urandom);
      ch = 4'($urandom);
      run_seq(l8, mc, ch, !mc ? "R2" : (l8 ? "R4" : "R3"));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule